// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block tells a four-bank DDR SDRAM controller when auto-refresh is due. An interval timer runs on the controller clock. Each expiry adds one to a count of owed refreshes. Commands can be busy when a refresh falls due, so the block does not insist on issuing it at once. It keeps a bounded backlog of postponed refreshes and raises a request to the command arbiter. The request is low priority until the backlog reaches its limit. At the limit it becomes urgent, and the block also asks the controller to close every bank so that the refresh can be issued.

A refresh counts as issued only when the arbiter grants it while every bank is idle. After each issued refresh, every command is held off for a fixed number of cycles, which covers the refresh row cycle time. Self-refresh entry is requested through an enable input. Entry is taken only while all banks are idle. During self-refresh the clock-enable output is low, the interval timer is frozen and the backlog is cleared. When the enable drops, the block raises clock enable again and holds off all commands for a fixed exit wait before normal traffic resumes.

The controller is modelled by a state machine with four states:
- **RUN**: normal operation, requests allowed.
- **RFC_WAIT**: post-refresh hold-off.
- **SELF**: in self-refresh, clock enable low.
- **EXIT_WAIT**: post-exit hold-off.

Its transitions are:
- **issue** (RUN→RFC_WAIT): the grant is accepted.
- **rfc_done** (RFC_WAIT→RUN): the hold-off count is spent.
- **sr_enter** (RUN→SELF): self-refresh is enabled, the banks are idle and no grant is present.
- **sr_leave** (SELF→EXIT_WAIT): the enable drops.
- **exit_done** (EXIT_WAIT→RUN): the exit wait is spent.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, the owed count is 0 and the request, urgent and close-banks outputs are low. Command block is low and clock enable is high.
- R2: Outside self-refresh, the owed count rises by one every INTERVAL clock cycles, counted from reset release or from the self-refresh exit edge.
- R3: The owed count never exceeds OWED_MAX and saturates there. The urgent output is high exactly when the count equals OWED_MAX.
- R4: The refresh request is high exactly when the machine is in RUN and the owed count is non-zero.
- R5: In RUN, the close-banks output is high whenever the request is urgent or self-refresh is enabled.
- R6: A grant is accepted only in RUN, with banks idle and a non-zero owed count. An accepted grant lowers the owed count by one. Any other grant leaves the count unchanged.
- R7: After an accepted grant, command block is high for exactly RFC_CYC cycles and the request is low throughout. Grants during that window are ignored.
- R8: In RUN, with self-refresh enabled, banks idle and no grant, the next cycle has clock enable low, owed count 0 and command block high. The owed count stays 0 while in self-refresh.
- R9: One cycle after self-refresh enable drops, clock enable is high. Command block then stays high for exactly XSR_CYC cycles counted from that edge.
- R10: If an interval expiry and an accepted grant fall in the same cycle, the owed count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter issues the refresh this cycle |
| banks_idle | input | 1 | All four banks are precharged |
| sr_en | input | 1 | Request to enter or stay in self-refresh |
| ref_req | output | 1 | Refresh wanted |
| ref_urgent | output | 1 | Backlog at limit; refresh must be serviced now |
| close_all | output | 1 | Ask the controller to precharge all banks |
| cmd_block | output | 1 | No command to any bank allowed |
| cke | output | 1 | Clock enable to the memory |
| owed_cnt | output | $clog2(OWED_MAX+1) | Number of owed refreshes |

## Verification
Every result is due one clock edge after the stimulus that causes it.
- The owed count moves on the edge where the interval expires, which is INTERVAL edges after reset or after the self-refresh exit edge.
- An accepted grant changes the count and raises command block on the same edge that samples it. Command block then stays high for the fixed hold-off count.
- Self-refresh entry and exit change clock enable on the edge that samples the enable.

The bench drives inputs just after a falling edge and samples on the next falling edge. It counts rising edges since reset, so each check lands on the exact cycle computed from the interval, the hold-off lengths and the sampling edge. The backlog sweep compares the count, request and urgent flag with floor(cycles/INTERVAL) clipped at the limit on every cycle.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_RFC_WAIT  = 2'd1,
        ST_SELF      = 2'd2,
        ST_EXIT_WAIT = 2'd3
    } rs_state_t;
endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (hold)    cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refsch_owed.sv
module refsch_owed #(
    parameter int OWED_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic [$clog2(OWED_MAX+1)-1:0] count,
    output logic full
);
    localparam int OW = $clog2(OWED_MAX + 1);
    localparam logic [OW-1:0] TOP = OW'(OWED_MAX);

    assign full = (count == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (clr)              count <= '0;
        else if (inc && !dec) begin
            if (!full)             count <= count + 1'b1;
        end
        else if (dec && !inc) begin
            if (count != '0)       count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/refsch_wait.sv
module refsch_wait #(
    parameter int MAX_LOAD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic [$clog2(MAX_LOAD+1)-1:0] load_val,
    output logic last
);
    localparam int WW = $clog2(MAX_LOAD + 1);

    logic [WW-1:0] cnt;

    assign last = (cnt == WW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int INTERVAL = 1040,
    parameter int OWED_MAX = 8,
    parameter int RFC_CYC  = 10,
    parameter int XSR_CYC  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    input  logic banks_idle,
    input  logic sr_en,
    output logic ref_req,
    output logic ref_urgent,
    output logic close_all,
    output logic cmd_block,
    output logic cke,
    output logic [$clog2(OWED_MAX+1)-1:0] owed_cnt
);
    localparam int WMAX = (RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC;
    localparam int WW   = $clog2(WMAX + 1);
    localparam logic [WW-1:0] RFC_LD = WW'(RFC_CYC);
    localparam logic [WW-1:0] XSR_LD = WW'(XSR_CYC);

    rs_state_t state, state_nx;

    logic tick, owed_full, wait_last;
    logic grant_ok, sr_go, sr_off, wait_load;
    logic [WW-1:0] wait_val;

    assign grant_ok  = (state == ST_RUN) && ref_grant && banks_idle && (owed_cnt != '0);
    assign sr_go     = (state == ST_RUN) && sr_en && banks_idle && !ref_grant;
    assign sr_off    = (state == ST_SELF) && !sr_en;
    assign wait_load = grant_ok || sr_off;
    assign wait_val  = grant_ok ? RFC_LD : XSR_LD;

    refsch_interval #(.INTERVAL(INTERVAL)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state == ST_SELF),
        .tick  (tick)
    );

    refsch_owed #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (grant_ok),
        .clr   (sr_go),
        .count (owed_cnt),
        .full  (owed_full)
    );

    refsch_wait #(.MAX_LOAD(WMAX)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .last     (wait_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (grant_ok)      state_nx = ST_RFC_WAIT;
                else if (sr_go)    state_nx = ST_SELF;
            end
            ST_RFC_WAIT:  if (wait_last) state_nx = ST_RUN;
            ST_SELF:      if (!sr_en)    state_nx = ST_EXIT_WAIT;
            ST_EXIT_WAIT: if (wait_last) state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        ref_urgent = owed_full;
        ref_req    = 1'b0;
        close_all  = 1'b0;
        cmd_block  = 1'b1;
        cke        = 1'b1;
        unique case (state)
            ST_RUN: begin
                cmd_block = 1'b0;
                ref_req   = (owed_cnt != '0);
                close_all = owed_full || sr_en;
            end
            ST_RFC_WAIT:  ;
            ST_SELF:      cke = 1'b0;
            ST_EXIT_WAIT: ;
            default:      ;
        endcase
    end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int OWED_MAX = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ref_grant,
    input logic banks_idle,
    input logic sr_en,
    input logic ref_req,
    input logic ref_urgent,
    input logic close_all,
    input logic cmd_block,
    input logic cke,
    input logic [$clog2(OWED_MAX+1)-1:0] owed_cnt
);
    // R3
    owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owed_cnt) <= OWED_MAX);

    // R2
    owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cke) |-> (int'(owed_cnt) <= int'($past(owed_cnt)) + 1 &&
                         int'(owed_cnt) + 1 >= int'($past(owed_cnt))));

    // R4
    req_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (owed_cnt != '0 && !cmd_block && cke));

    // R7
    grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && banks_idle && ref_req) |=> (cmd_block && !ref_req));

    // R6
    busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !banks_idle |=> int'(owed_cnt) >= int'($past(owed_cnt)));

    // R8
    self_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_block && owed_cnt == '0));

    // R9
    exit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd_block);
endmodule

bind refresh_sched refresh_sched_chk #(.OWED_MAX(OWED_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_grant  (ref_grant),
    .banks_idle (banks_idle),
    .sr_en      (sr_en),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .close_all  (close_all),
    .cmd_block  (cmd_block),
    .cke        (cke),
    .owed_cnt   (owed_cnt)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int IVL  = 16;
    localparam int OMAX = 8;
    localparam int RFC  = 4;
    localparam int XSR  = 12;
    localparam int OW   = $clog2(OMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_grant = 1'b0, banks_idle = 1'b0, sr_en = 1'b0;
    logic ref_req, ref_urgent, close_all, cmd_block, cke;
    logic [OW-1:0] owed_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(.INTERVAL(IVL), .OWED_MAX(OMAX), .RFC_CYC(RFC), .XSR_CYC(XSR)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
        .sr_en(sr_en), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .close_all(close_all), .cmd_block(cmd_block), .cke(cke), .owed_cnt(owed_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_grant = 1'b0; banks_idle = 1'b0; sr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset values
        @(negedge clk);
        chk("R1 owed", int'(owed_cnt), 0);
        chk("R1 req", int'(ref_req), 0);
        chk("R1 urgent", int'(ref_urgent), 0);
        chk("R1 close", int'(close_all), 0);
        chk("R1 block", int'(cmd_block), 0);
        chk("R1 cke", int'(cke), 1);

        // Backlog sweep: R2 R3 R4, arithmetic expectation
        do_reset();
        for (int k = 1; k <= 10 * IVL; k++) begin
            int e;
            step(1);
            e = (k / IVL > OMAX) ? OMAX : k / IVL;
            chk("R2 owed", int'(owed_cnt), e);
            chk("R3 urgent", int'(ref_urgent), int'(e == OMAX));
            chk("R4 req", int'(ref_req), int'(e != 0));
        end
        chk("R5 close on urgent", int'(close_all), 1);

        // R6 grant while banks busy ignored (cyc 160 -> 161)
        ref_grant = 1'b1; banks_idle = 1'b0;
        step(1);
        chk("R6 busy grant", int'(owed_cnt), OMAX);
        chk("R6 busy block", int'(cmd_block), 0);
        banks_idle = 1'b1;
        step(1); // accepted at edge 162
        chk("R6 decrement", int'(owed_cnt), OMAX - 1);
        chk("R3 urgent drop", int'(ref_urgent), 0);
        for (int k = 1; k < RFC; k++) begin
            chk("R7 block", int'(cmd_block), 1);
            chk("R7 req low", int'(ref_req), 0);
            step(1); // grant held high: ignored
        end
        chk("R7 block last", int'(cmd_block), 1);
        ref_grant = 1'b0;
        step(1);
        chk("R7 block end", int'(cmd_block), 0);
        chk("R7 grants ignored", int'(owed_cnt), OMAX - 1);
        chk("R4 req back", int'(ref_req), 1);

        // R6 single grant drains one owed refresh
        do_reset();
        step(IVL);
        chk("R2 first", int'(owed_cnt), 1);
        ref_grant = 1'b1; banks_idle = 1'b1;
        step(1);
        ref_grant = 1'b0;
        chk("R6 to zero", int'(owed_cnt), 0);
        chk("R4 req zero", int'(ref_req), 0);
        step(RFC);
        chk("R6 zero grant", int'(cmd_block), 0);
        ref_grant = 1'b1;
        step(1);
        ref_grant = 1'b0;
        chk("R6 grant with nothing owed", int'(cmd_block), 0);

        // R10 expiry and grant in same cycle (edge 2*IVL)
        do_reset();
        step(2 * IVL - 1);
        chk("R10 pre", int'(owed_cnt), 1);
        ref_grant = 1'b1; banks_idle = 1'b1;
        step(1);
        ref_grant = 1'b0;
        chk("R10 net", int'(owed_cnt), 1);
        chk("R10 block", int'(cmd_block), 1);

        // Self-refresh entry and exit: R5 R8 R9 R2
        do_reset();
        step(IVL + 4);
        sr_en = 1'b1; banks_idle = 1'b0;
        step(2);
        chk("R5 close on sr", int'(close_all), 1);
        chk("R8 no entry busy", int'(cke), 1);
        banks_idle = 1'b1;
        step(1);
        chk("R8 cke low", int'(cke), 0);
        chk("R8 owed clear", int'(owed_cnt), 0);
        chk("R8 block", int'(cmd_block), 1);
        chk("R8 req", int'(ref_req), 0);
        step(3 * IVL);
        chk("R8 stay", int'(cke), 0);
        chk("R8 owed frozen", int'(owed_cnt), 0);
        sr_en = 1'b0;
        for (int k = 1; k <= IVL + 1; k++) begin
            step(1);
            if (k == 1) chk("R9 cke up", int'(cke), 1);
            chk("R9 block", int'(cmd_block), int'(k <= XSR));
            chk("R2 after exit", int'(owed_cnt), int'(k == IVL + 1));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule